// File: doc/BRIEF.md
# Extended Bus Address Multiplexer

This block runs the host side of a backplane bus cycle. The bus has a 16-bit data path that is shared between address and data, and a 24-bit memory address space. A CPU-side request gives the kind of cycle (memory or I/O), the direction, the address and the write data, together with a one-clock cycle strobe. The block then runs a bus cycle with a one-clock address phase and a data phase. The data phase ends when the addressed slave raises its ready handshake.

During the address phase of a memory cycle, the four address bits above the low 16 go onto the low data byte. The four bits above those go onto the high data byte. A slave can therefore latch the full 24-bit address from the data lines. I/O cycles carry only a 16-bit address and do not use the data lines in the address phase. An active-low expansion qualifier marks I/O cycles that fall in the top 1 KiB I/O window. A local control port at I/O address 0x0092 gates address bit 20. Accesses to this port are handled inside the block and never reach the bus.

Top module: `ext_bus_mux`

## Requirements
- R1: After reset the bus is idle: busMemRqN, busIoRqN, busRdN, busWrN and busIoExpN are 1, busDataOe is 0, cpuDone is 0, and address bit 20 is enabled (a read of port 0x0092 returns 0x0000).
- R2: A memory request runs an address phase of exactly one clock, starting the cycle after the strobe. In that phase busMemRqN=0, busRdN=busWrN=1, busAddr carries the 24-bit address, busDataOe=1, and busDataOut bits 3:0 carry address bits 19:16, bits 11:8 carry address bits 23:20, and all other bits are 0.
- R3: In the data phase of a write, busWrN=0, busDataOe=1 and busDataOut carries the write data. In the data phase of a read, busRdN=0 and busDataOe=0. Either strobe holds until busRdy=1 is seen.
- R4: The clock edge at which busRdy=1 is seen in the data phase ends the cycle. In the next cycle cpuDone=1 for one clock, with cpuRdata equal to the busDataIn sampled at that edge for a read, or 0 for a write, and the bus is idle again.
- R5: An I/O request (reqIsIo=1) drives busIoRqN=0 for the whole cycle, and busAddr carries the low 16 request address bits with bits 23:16 at 0. In its address phase busDataOe=0.
- R6: busIoExpN is 0 for the whole of an I/O cycle whose 16-bit address lies in 0xFC00..0xFFFF. It is 1 for every other I/O address, for memory cycles and while idle.
- R7: An I/O request to address 0x0092 is local. It gives no bus strobe, cpuDone=1 follows in the next cycle, and a write stores reqWdata bit 1 as the gate control, where 1 disables address bit 20 and 0 enables it. A read returns the stored bit in bit 1 and 0 in all other bits. A memory request to address 0x000092 goes to the bus.
- R8: While address bit 20 is disabled, memory cycles drive busAddr bit 20 and busDataOut bit 8 to 0 in the address phase. All other address bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Cycle strobe, one clock per request |
| reqIsIo | input | 1 | 1 = I/O request, 0 = memory request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Request address |
| reqWdata | input | 16 | Request write data |
| cpuDone | output | 1 | Request complete, one-clock pulse |
| cpuRdata | output | 16 | Read result, valid with cpuDone |
| busAddr | output | 24 | Backplane address lines |
| busDataOut | output | 16 | Data lines, driven value |
| busDataOe | output | 1 | Data line output enable |
| busDataIn | input | 16 | Data lines, received value |
| busMemRqN | output | 1 | Memory cycle strobe, active low |
| busIoRqN | output | 1 | I/O cycle strobe, active low |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| busIoExpN | output | 1 | High I/O window qualifier, active low |
| busRdy | input | 1 | Slave cycle-done handshake, active high |

## Verification
The assertions assume that the slave raises busRdy only while a read or write strobe is low. They also assume that reqValid is pulsed only while the block is idle and not in the same cycle as cpuDone. The stimulus keeps to both rules. Each request is a one-clock strobe, and every driver task waits for its own cpuDone before the next one starts. The bus responder in the bench raises busRdy only in the data phase, after the wait count set for that request.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} busState_t;

  typedef struct packed {
    logic capture;    // latch a bus request
    logic localAcc;   // access to the local gate port
    logic addrPhase;  // address phase of a bus cycle
    logic dataPhase;  // data phase of a bus cycle
    logic finish;     // slave handshake seen in data phase
  } ebmCtl_t;
endpackage

// File: rtl/ebm_ctrl.sv
module ebm_ctrl
  import ebm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    reqIsLocal,
  input  logic    busRdy,
  output ebmCtl_t ctl
);
  busState_t state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqIsLocal) ctl.localAcc = 1'b1;
          else begin
            ctl.capture = 1'b1;
            stateNext   = ST_ADDR;
          end
        end
      end
      ST_ADDR: begin
        ctl.addrPhase = 1'b1;
        stateNext     = ST_DATA;
      end
      ST_DATA: begin
        ctl.dataPhase = 1'b1;
        ctl.finish    = busRdy;
        if (busRdy) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end
endmodule

// File: rtl/ebm_datapath.sv
module ebm_datapath
  import ebm_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int          DATA_W      = 16,
  parameter int          IO_W        = 16,
  parameter logic [15:0] LOCAL_PORT  = 16'h0092,
  parameter logic [15:0] EXP_BASE    = 16'hFC00,
  parameter int          GATE_BIT    = 20,
  parameter int          CTL_BIT     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ebmCtl_t           ctl,
  input  logic              reqIsIo,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              reqIsLocal,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              busMemRqN,
  output logic              busIoRqN,
  output logic              busRdN,
  output logic              busWrN,
  output logic              busIoExpN,
  output logic              a20Dis
);
  localparam int NIB       = 4;
  localparam int LANE_W    = DATA_W / 2;
  localparam int HIGH_W    = ADDR_W - IO_W;
  localparam int MUX_LANES = HIGH_W / NIB;

  logic [ADDR_W-1:0] curAddr, effAddr;
  logic              curIsIo, curWrite, curExp;
  logic [DATA_W-1:0] curWdata, muxWord, localRd;
  logic              inCycle, reqExp;

  assign reqIsLocal = reqIsIo && (reqAddr[IO_W-1:0] == LOCAL_PORT);
  assign reqExp     = reqIsIo && (reqAddr[IO_W-1:0] >= EXP_BASE);

  always_comb begin
    effAddr = reqAddr;
    if (reqIsIo) effAddr[ADDR_W-1:IO_W] = '0;
    else if (a20Dis) effAddr[GATE_BIT] = 1'b0;
  end

  always_comb begin
    localRd = '0;
    localRd[CTL_BIT] = a20Dis;
  end

  // upper address nibbles, one per data lane
  generate
    for (genvar lane = 0; lane < MUX_LANES; lane++) begin : g_lane
      assign muxWord[lane*LANE_W +: LANE_W] =
        {{(LANE_W-NIB){1'b0}}, curAddr[IO_W + lane*NIB +: NIB]};
    end
    if (MUX_LANES * LANE_W < DATA_W) begin : g_pad
      assign muxWord[DATA_W-1:MUX_LANES*LANE_W] = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr  <= '0;
      curIsIo  <= 1'b0;
      curWrite <= 1'b0;
      curExp   <= 1'b0;
      curWdata <= '0;
    end else if (ctl.capture) begin
      curAddr  <= effAddr;
      curIsIo  <= reqIsIo;
      curWrite <= reqWrite;
      curExp   <= reqExp;
      curWdata <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a20Dis <= 1'b0;
    else if (ctl.localAcc && reqWrite) a20Dis <= reqWdata[CTL_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpuDone  <= 1'b0;
      cpuRdata <= '0;
    end else begin
      cpuDone <= ctl.finish | ctl.localAcc;
      if (ctl.finish)        cpuRdata <= curWrite ? '0 : busDataIn;
      else if (ctl.localAcc) cpuRdata <= reqWrite ? '0 : localRd;
    end
  end

  assign inCycle    = ctl.addrPhase | ctl.dataPhase;
  assign busAddr    = inCycle ? curAddr : '0;
  assign busDataOe  = (ctl.addrPhase && !curIsIo) || (ctl.dataPhase && curWrite);
  assign busDataOut = (ctl.addrPhase && !curIsIo) ? muxWord :
                      (ctl.dataPhase && curWrite) ? curWdata : '0;
  assign busMemRqN  = !(inCycle && !curIsIo);
  assign busIoRqN   = !(inCycle && curIsIo);
  assign busRdN     = !(ctl.dataPhase && !curWrite);
  assign busWrN     = !(ctl.dataPhase && curWrite);
  assign busIoExpN  = !(inCycle && curExp);
endmodule

// File: rtl/ext_bus_mux.sv
module ext_bus_mux
  import ebm_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqIsIo,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              busMemRqN,
  output logic              busIoRqN,
  output logic              busRdN,
  output logic              busWrN,
  output logic              busIoExpN,
  input  logic              busRdy
);
  ebmCtl_t ctl;
  logic    reqIsLocal;
  logic    a20Dis;

  ebm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqIsLocal(reqIsLocal),
    .busRdy(busRdy), .ctl(ctl)
  );

  ebm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .reqIsIo(reqIsIo), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busDataIn(busDataIn),
    .reqIsLocal(reqIsLocal), .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .busAddr(busAddr), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busMemRqN(busMemRqN), .busIoRqN(busIoRqN), .busRdN(busRdN),
    .busWrN(busWrN), .busIoExpN(busIoExpN), .a20Dis(a20Dis)
  );
endmodule

// File: rtl/ebm_checker.sv
module ebm_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busMemRqN,
  input logic              busIoRqN,
  input logic              busRdN,
  input logic              busWrN,
  input logic              busIoExpN,
  input logic              busDataOe,
  input logic              busRdy,
  input logic [ADDR_W-1:0] busAddr,
  input logic              a20Dis
);
  logic memAddrPhase;
  assign memAddrPhase = !busMemRqN && busRdN && busWrN;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (busMemRqN && busIoRqN) |-> (busIoExpN && !busDataOe && busRdN && busWrN)); // R1
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(!busMemRqN && !busIoRqN)); // R2
  AST_ADDR_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    memAddrPhase |=> !memAddrPhase); // R2
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(busRdN && busWrN) && !busRdy) |=> ($stable(busRdN) && $stable(busWrN))); // R3
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !busRdN |-> !busDataOe); // R3
  AST_IO_NO_MUX: assert property (@(posedge clk) disable iff (!rst_n)
    (!busIoRqN && busRdN && busWrN) |-> !busDataOe); // R5
  AST_IO_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busIoRqN |-> (busAddr[ADDR_W-1:16] == '0)); // R5
  AST_EXP_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !busMemRqN |-> busIoExpN); // R6
  AST_A20_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (a20Dis && !busMemRqN) |-> !busAddr[20]); // R8
endmodule

bind ext_bus_mux ebm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busMemRqN(busMemRqN), .busIoRqN(busIoRqN),
  .busRdN(busRdN), .busWrN(busWrN), .busIoExpN(busIoExpN),
  .busDataOe(busDataOe), .busRdy(busRdy), .busAddr(busAddr), .a20Dis(a20Dis)
);

// File: tb/ext_bus_mux_test.sv
module ext_bus_mux_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0, reqIsIo = 1'b0, reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqWdata = '0, busDataIn = '0;
  logic        busRdy = 1'b0;
  logic        cpuDone, busDataOe, busMemRqN, busIoRqN, busRdN, busWrN, busIoExpN;
  logic [15:0] cpuRdata, busDataOut;
  logic [23:0] busAddr;

  int checks = 0, failures = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  bit          gateOff = 1'b0;

  always #4 clk = ~clk;

  ext_bus_mux uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqIsIo(reqIsIo),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cpuDone(cpuDone), .cpuRdata(cpuRdata), .busAddr(busAddr),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .busDataIn(busDataIn),
    .busMemRqN(busMemRqN), .busIoRqN(busIoRqN), .busRdN(busRdN),
    .busWrN(busWrN), .busIoExpN(busIoExpN), .busRdy(busRdy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic chkIdle(input string tag);
    chkEq({tag, " strobes"}, {busMemRqN, busIoRqN, busRdN, busWrN, busIoExpN}, 5'h1F);
    chkEq({tag, " oe"}, busDataOe, 0);
  endtask

  // monitor: pop the scoreboard on each completion
  always @(negedge clk) begin
    if (rst_n && cpuDone) begin
      if (expQ.size() == 0) chk(1'b0, "R4 unexpected done", 1, 0);
      else begin
        automatic logic [15:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        chkEq({t, " rdata"}, cpuRdata, e);
      end
    end
  end

  function automatic logic [15:0] muxOf(input logic [23:0] a);
    return {4'h0, a[23:21], a[20] & ~gateOff, 4'h0, a[19:16]};
  endfunction

  task automatic busCycle(input bit io, input bit wr, input logic [23:0] a,
                          input logic [15:0] wd, input logic [15:0] rd,
                          input int waits, input string tag);
    logic [23:0] ea;
    bit expWin;
    ea = io ? {8'h00, a[15:0]} : {a[23:21], a[20] & ~gateOff, a[19:0]};
    expWin = io && (a[15:0] >= 16'hFC00);
    @(negedge clk);
    reqValid = 1'b1; reqIsIo = io; reqWrite = wr; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0; reqWdata = 16'h0;
    // address phase
    chkEq({tag, " R2/R5 addr"}, busAddr, ea);
    chkEq({tag, " R2 kind"}, {busMemRqN, busIoRqN, busRdN, busWrN}, io ? 4'b1011 : 4'b0111);
    chkEq({tag, " R6 exp"}, busIoExpN, !expWin);
    if (io) chkEq({tag, " R5 no mux"}, busDataOe, 0);
    else begin
      chkEq({tag, " R2 oe"}, busDataOe, 1);
      chkEq({tag, " R2/R8 mux"}, busDataOut, muxOf(a));
    end
    for (int k = 0; k <= waits; k++) begin
      @(negedge clk);
      chkEq({tag, " R3 strobes"}, {busRdN, busWrN}, wr ? 2'b10 : 2'b01);
      chkEq({tag, " R3 oe"}, busDataOe, wr);
      if (wr) chkEq({tag, " R3 wdata"}, busDataOut, wd);
      chkEq({tag, " R6 exp data"}, busIoExpN, !expWin);
      chkEq({tag, " R5 addr hold"}, busAddr, ea);
    end
    busRdy = 1'b1; busDataIn = rd;
    expQ.push_back(wr ? 16'h0 : rd); tagQ.push_back({tag, " R4"});
    @(negedge clk);
    busRdy = 1'b0; busDataIn = 16'h0;
    chkEq({tag, " R4 done"}, cpuDone, 1);
    chkIdle({tag, " R4 idle"});
    @(negedge clk);
    chkEq({tag, " R4 pulse"}, cpuDone, 0);
  endtask

  task automatic localAcc(input bit wr, input logic [15:0] wd, input logic [15:0] expRd,
                          input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqIsIo = 1'b1; reqWrite = wr; reqAddr = 24'h330092; reqWdata = wd;
    expQ.push_back(wr ? 16'h0 : expRd); tagQ.push_back({tag, " R7"});
    @(negedge clk);
    reqValid = 1'b0;
    chkEq({tag, " R7 done"}, cpuDone, 1);
    chkIdle({tag, " R7 quiet"});
    @(negedge clk);
    chkIdle({tag, " R7 quiet2"});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chkIdle("R1 reset");
    chkEq("R1 done", cpuDone, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chkIdle("R1 after");
    localAcc(1'b0, 16'h0, 16'h0000, "R1 gate read");
    busCycle(1'b0, 1'b1, 24'hA51234, 16'hBEEF, 16'h0, 2, "R2 memwr");
    busCycle(1'b0, 1'b0, 24'h3C0010, 16'h0, 16'h1357, 0, "R4 memrd");
    busCycle(1'b1, 1'b1, 24'h5AFC00, 16'h1111, 16'h0, 1, "R6 io lo edge");
    busCycle(1'b1, 1'b0, 24'h00FFFF, 16'h0, 16'hCAFE, 0, "R6 io hi edge");
    busCycle(1'b1, 1'b1, 24'h00FBFF, 16'h2222, 16'h0, 0, "R6 io below");
    busCycle(1'b1, 1'b0, 24'hFF0010, 16'h0, 16'h4444, 3, "R5 io rd");
    localAcc(1'b1, 16'hFFFF, 16'h0, "R7 gate off");
    gateOff = 1'b1;
    localAcc(1'b0, 16'h0, 16'h0002, "R7 gate read");
    busCycle(1'b0, 1'b0, 24'hFFFFFF, 16'h0, 16'h8001, 0, "R8 gated");
    busCycle(1'b0, 1'b1, 24'h100000, 16'h5555, 16'h0, 1, "R8 gated wr");
    localAcc(1'b1, 16'hFFFD, 16'h0, "R7 gate on");
    gateOff = 1'b0;
    localAcc(1'b0, 16'h0, 16'h0000, "R7 gate read2");
    busCycle(1'b0, 1'b0, 24'h100000, 16'h0, 16'h7777, 0, "R8 open");
    busCycle(1'b0, 1'b0, 24'h000092, 16'h0, 16'h9292, 0, "R7 mem92");
    repeat (2) @(negedge clk);
    chkEq("R4 queue empty", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule